// File: doc/BRIEF.md
# Asynchronous Static-Memory Bus Master

This block sits on the controller side of an external asynchronous static-memory bus. It takes one read or write at a time from an internal request port and turns it into a single SRAM-style bus cycle. The upper bits of a 30-bit byte-space address pick one of four chip selects, so each chip select covers a 256 MB window. The remaining bits are driven on a non-multiplexed address bus that stays valid for the whole cycle. The data bus is 16 bits wide. Output enable strobes reads and write enable strobes writes.

Each bank has its own set of four cycle counts: address setup, data setup, hold and turnaround. A small configuration port loads these counts. The set that belongs to the addressed bank is captured when a request is accepted and governs the whole cycle. Reads and writes use the same set. A cycle first asserts the chip select and drives the address. The address-setup count then elapses. The strobe is then held low for the data-setup count and released. The hold and turnaround counts follow, and only after them is the chip select released. Acknowledge pulses for one clock once the cycle has finished.

The bidirectional data pin is split into an output value, an output enable and an input value, and the pad ring combines them. Reset is asynchronous and active low, and its release is synchronised internally over two clocks.

Top module: `sbm_top`

## Requirements
- R1: After reset all chip selects, output enable and write enable are high, the data-bus enable is low, acknowledge is low and the request port is ready.
- R2: Address bits [29:28] choose the chip select (value b drives mem_cs_n[b] low). At most one chip select is low at any time, and only while a cycle is in progress.
- R3: mem_addr carries request address bits [27:0] and holds steady for every cycle in which a chip select is low.
- R4: The strobe falls after the chip select has been low for exactly the bank's address-setup count of clocks. A count of 0 makes both fall in the same clock.
- R5: The strobe stays low for the bank's data-setup count of clocks. A count of 0 is treated as 1.
- R6: After the strobe rises, the chip select stays low for hold plus turnaround clocks. Zero values add no clocks. Acknowledge is high in the first clock after the chip select rises.
- R7: A read lowers only output enable. rdata takes mem_dq_in at the clock edge that ends the data-setup phase. Acknowledge lasts exactly one clock.
- R8: A write lowers only write enable. mem_dq_out carries the write data, and mem_dq_oe is high from the first chip-select clock through the end of the hold phase and low otherwise. This includes the turnaround phase.
- R9: A configuration write (cfg_we with cfg_bank) changes only the named bank's counts. Every access uses the counts of the bank it addresses.
- R10: The port accepts a request only when req_ready is high, and it is low for the whole cycle. A request held while busy starts no bus activity, and each accepted request produces exactly one bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load the timing set of cfg_bank |
| cfg_bank | input | 2 | Bank whose timing set is loaded |
| cfg_addset | input | 5 | Address-setup count |
| cfg_datset | input | 5 | Data-setup count |
| cfg_hold | input | 5 | Hold count |
| cfg_turn | input | 5 | Turnaround count |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to accept |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 30 | Request address |
| req_wdata | input | 16 | Write data |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Last read data |
| mem_cs_n | output | 4 | Active-low chip selects |
| mem_addr | output | 28 | External address bus |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 16 | Data driven towards memory |
| mem_dq_oe | output | 1 | Data-bus drive enable |
| mem_dq_in | input | 16 | Data returned by memory |

## Verification
The assertions check on every clock the rules that hold in any timing configuration. They cover a single active chip select, strobes that occur only under a chip select and never together, an address held steady through a cycle, a data bus that is never driven while output enable is low, and a one-clock acknowledge. The exact phase lengths for a given timing set can only be shown by the bench scenarios. The same is true of the zero-count corner cases, the per-bank isolation of configuration writes, the read sample landing on the last data-setup clock, and requests ignored while busy. The bench counts clocks at the pins against counts it derives itself.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

  localparam int TIM_W = 5;

  typedef struct packed {
    logic [TIM_W-1:0] addset;
    logic [TIM_W-1:0] datset;
    logic [TIM_W-1:0] hold;
    logic [TIM_W-1:0] turn;
  } bank_timing_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_DATA = 3'd2,
    ST_HOLD = 3'd3,
    ST_TURN = 3'd4
  } seq_state_t;

endpackage

// File: rtl/sbm_timing_regs.sv
module sbm_timing_regs
  import sbm_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int BANK_W     = $clog2(NUM_BANKS),
  parameter int DEF_ADDSET = 14,
  parameter int DEF_DATSET = 16,
  parameter int DEF_HOLD   = 0,
  parameter int DEF_TURN   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wr_bank,
  input  bank_timing_t      wr_val,
  input  logic [BANK_W-1:0] rd_bank,
  output bank_timing_t      rd_val
);

  localparam bank_timing_t RESET_VAL = '{
    addset: TIM_W'(DEF_ADDSET),
    datset: TIM_W'(DEF_DATSET),
    hold:   TIM_W'(DEF_HOLD),
    turn:   TIM_W'(DEF_TURN)
  };

  bank_timing_t tim_q [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic         load_en;
    bank_timing_t tim_d;

    always_comb begin
      load_en = wr_en && (wr_bank == BANK_W'(b));
      tim_d   = load_en ? wr_val : tim_q[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tim_q[b] <= RESET_VAL;
      else        tim_q[b] <= tim_d;
    end
  end

  assign rd_val = tim_q[rd_bank];

endmodule

// File: rtl/sbm_bank_decode.sv
module sbm_bank_decode #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic                 active,
  input  logic [BANK_W-1:0]    bank,
  output logic [NUM_BANKS-1:0] cs_n
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cs
    assign cs_n[b] = !(active && (bank == BANK_W'(b)));
  end

endmodule

// File: rtl/sbm_sequencer.sv
module sbm_sequencer
  import sbm_pkg::*;
#(
  parameter int MADDR_W = 28,
  parameter int DATA_W  = 16,
  parameter int BANK_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_we,
  input  logic [BANK_W-1:0]  req_bank,
  input  logic [MADDR_W-1:0] req_maddr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  bank_timing_t       tim_in,
  input  logic [DATA_W-1:0]  dq_in,
  output logic               req_ready,
  output logic               ack,
  output logic [DATA_W-1:0]  rdata,
  output logic               active,
  output logic [BANK_W-1:0]  cur_bank,
  output logic [MADDR_W-1:0] maddr,
  output logic               oe_n,
  output logic               we_n,
  output logic [DATA_W-1:0]  dq_out,
  output logic               dq_oe
);

  seq_state_t         state_q, state_d;
  logic [TIM_W-1:0]   cnt_q, cnt_d;
  bank_timing_t       tim_q, tim_d;
  logic [MADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0]  wdata_q, wdata_d;
  logic               we_q, we_d;
  logic [BANK_W-1:0]  bank_q, bank_d;
  logic               ack_q, ack_d;
  logic [DATA_W-1:0]  rdata_q;
  logic               rdata_en;
  logic               accept;
  logic               last_cnt;

  function automatic logic [TIM_W-1:0] data_load(input logic [TIM_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  assign accept   = (state_q == ST_IDLE) && req_valid;
  assign last_cnt = (cnt_q == '0);
  assign rdata_en = (state_q == ST_DATA) && last_cnt && !we_q;

  // next-state process
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    tim_d   = tim_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    we_d    = we_q;
    bank_d  = bank_q;
    ack_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          tim_d   = tim_in;
          addr_d  = req_maddr;
          wdata_d = req_wdata;
          we_d    = req_we;
          bank_d  = req_bank;
          if (tim_in.addset != '0) begin
            state_d = ST_ADDR;
            cnt_d   = tim_in.addset - 1'b1;
          end else begin
            state_d = ST_DATA;
            cnt_d   = data_load(tim_in.datset);
          end
        end
      end
      ST_ADDR: begin
        if (last_cnt) begin
          state_d = ST_DATA;
          cnt_d   = data_load(tim_q.datset);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_DATA: begin
        if (last_cnt) begin
          if (tim_q.hold != '0) begin
            state_d = ST_HOLD;
            cnt_d   = tim_q.hold - 1'b1;
          end else if (tim_q.turn != '0) begin
            state_d = ST_TURN;
            cnt_d   = tim_q.turn - 1'b1;
          end else begin
            state_d = ST_IDLE;
            ack_d   = 1'b1;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_HOLD: begin
        if (last_cnt) begin
          if (tim_q.turn != '0) begin
            state_d = ST_TURN;
            cnt_d   = tim_q.turn - 1'b1;
          end else begin
            state_d = ST_IDLE;
            ack_d   = 1'b1;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_TURN: begin
        if (last_cnt) begin
          state_d = ST_IDLE;
          ack_d   = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      tim_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      bank_q  <= '0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      tim_q   <= tim_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      we_q    <= we_d;
      bank_q  <= bank_d;
      ack_q   <= ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= dq_in;
  end

  assign req_ready = (state_q == ST_IDLE);
  assign ack       = ack_q;
  assign rdata     = rdata_q;
  assign active    = (state_q != ST_IDLE);
  assign cur_bank  = bank_q;
  assign maddr     = addr_q;
  assign oe_n      = !((state_q == ST_DATA) && !we_q);
  assign we_n      = !((state_q == ST_DATA) && we_q);
  assign dq_out    = wdata_q;
  assign dq_oe     = we_q && ((state_q == ST_ADDR) || (state_q == ST_DATA) ||
                              (state_q == ST_HOLD));

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));

  // R7
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R3
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(maddr));

  // R8
  dq_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n);

  // R10
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !req_ready);

endmodule

// File: rtl/sbm_top.sv
module sbm_top
  import sbm_pkg::*;
#(
  parameter int ADDR_W     = 30,
  parameter int DATA_W     = 16,
  parameter int NUM_BANKS  = 4,
  parameter int DEF_ADDSET = 14,
  parameter int DEF_DATSET = 16,
  parameter int DEF_HOLD   = 0,
  parameter int DEF_TURN   = 0,
  localparam int BANK_W    = $clog2(NUM_BANKS),
  localparam int MADDR_W   = ADDR_W - BANK_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [BANK_W-1:0]    cfg_bank,
  input  logic [TIM_W-1:0]     cfg_addset,
  input  logic [TIM_W-1:0]     cfg_datset,
  input  logic [TIM_W-1:0]     cfg_hold,
  input  logic [TIM_W-1:0]     cfg_turn,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_we,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 ack,
  output logic [DATA_W-1:0]    rdata,
  output logic [NUM_BANKS-1:0] mem_cs_n,
  output logic [MADDR_W-1:0]   mem_addr,
  output logic                 mem_oe_n,
  output logic                 mem_we_n,
  output logic [DATA_W-1:0]    mem_dq_out,
  output logic                 mem_dq_oe,
  input  logic [DATA_W-1:0]    mem_dq_in
);

  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic [BANK_W-1:0] req_bank;
  bank_timing_t      cfg_val;
  bank_timing_t      sel_tim;
  logic              active;
  logic [BANK_W-1:0] cur_bank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  assign req_bank = req_addr[ADDR_W-1 -: BANK_W];
  assign cfg_val  = '{addset: cfg_addset, datset: cfg_datset,
                      hold: cfg_hold, turn: cfg_turn};

  sbm_timing_regs #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .DEF_ADDSET(DEF_ADDSET),
    .DEF_DATSET(DEF_DATSET),
    .DEF_HOLD  (DEF_HOLD),
    .DEF_TURN  (DEF_TURN)
  ) u_timing (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .wr_en  (cfg_we),
    .wr_bank(cfg_bank),
    .wr_val (cfg_val),
    .rd_bank(req_bank),
    .rd_val (sel_tim)
  );

  sbm_sequencer #(
    .MADDR_W(MADDR_W),
    .DATA_W (DATA_W),
    .BANK_W (BANK_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .req_valid(req_valid),
    .req_we   (req_we),
    .req_bank (req_bank),
    .req_maddr(req_addr[MADDR_W-1:0]),
    .req_wdata(req_wdata),
    .tim_in   (sel_tim),
    .dq_in    (mem_dq_in),
    .req_ready(req_ready),
    .ack      (ack),
    .rdata    (rdata),
    .active   (active),
    .cur_bank (cur_bank),
    .maddr    (mem_addr),
    .oe_n     (mem_oe_n),
    .we_n     (mem_we_n),
    .dq_out   (mem_dq_out),
    .dq_oe    (mem_dq_oe)
  );

  sbm_bank_decode #(
    .NUM_BANKS(NUM_BANKS),
    .BANK_W   (BANK_W)
  ) u_decode (
    .active(active),
    .bank  (cur_bank),
    .cs_n  (mem_cs_n)
  );

  // R2
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    $onehot0(~mem_cs_n));

  // R4
  strobe_under_cs_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!mem_oe_n || !mem_we_n) |-> (mem_cs_n != '1));

  // R6
  ack_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    ack |-> (mem_cs_n == '1));

endmodule

// File: tb/sbm_top_bench.sv
module sbm_top_bench;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_bank;
  logic [4:0]  cfg_addset, cfg_datset, cfg_hold, cfg_turn;
  logic        req_valid;
  logic        req_ready;
  logic        req_we;
  logic [29:0] req_addr;
  logic [15:0] req_wdata;
  logic        ack;
  logic [15:0] rdata;
  logic [3:0]  mem_cs_n;
  logic [27:0] mem_addr;
  logic        mem_oe_n;
  logic        mem_we_n;
  logic [15:0] mem_dq_out;
  logic        mem_dq_oe;
  logic [15:0] mem_dq_in;

  int checks = 0;
  int errors = 0;
  int exp_a [4];
  int exp_d [4];
  int exp_h [4];
  int exp_t [4];
  int oe_cnt = 0;

  sbm_top u_sbm_top (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_addset(cfg_addset),
    .cfg_datset(cfg_datset), .cfg_hold(cfg_hold), .cfg_turn(cfg_turn),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rdata(rdata),
    .mem_cs_n(mem_cs_n), .mem_addr(mem_addr), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] model_base(input logic [27:0] a);
    return a[15:0] ^ 16'h3C00;
  endfunction

  // memory model: the returned word advances on every clock output enable is low
  always @(negedge clk) begin
    if (!mem_oe_n) begin
      oe_cnt    = oe_cnt + 1;
      mem_dq_in = model_base(mem_addr) + 16'(oe_cnt - 1);
    end else begin
      oe_cnt    = 0;
      mem_dq_in = 16'hFFFF;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic set_timing(input int b, input int a, input int d, input int h, input int t);
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank = 2'(b);
    cfg_addset = 5'(a); cfg_datset = 5'(d); cfg_hold = 5'(h); cfg_turn = 5'(t);
    @(negedge clk);
    cfg_we = 1'b0;
    exp_a[b] = a; exp_d[b] = d; exp_h[b] = h; exp_t[b] = t;
  endtask

  // one access, measured at the pins clock by clock
  task automatic access(input int b, input bit wr, input logic [27:0] off, input logic [15:0] wd);
    int dm, len, first_cs, last_cs, first_stb, stb_cnt, oe_first, oe_last, oe_cnt_l;
    int ack_n, bad_cs, bad_addr, bad_strobe, bad_wdata;
    logic [15:0] rd_at_ack;
    dm  = (exp_d[b] == 0) ? 1 : exp_d[b];
    len = exp_a[b] + dm + exp_h[b] + exp_t[b];
    first_cs = -1; last_cs = -1; first_stb = -1; stb_cnt = 0;
    oe_first = -1; oe_last = -1; oe_cnt_l = 0; ack_n = -1;
    bad_cs = 0; bad_addr = 0; bad_strobe = 0; bad_wdata = 0; rd_at_ack = '0;
    @(negedge clk);
    req_valid = 1'b1; req_we = wr; req_addr = {2'(b), off}; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    for (int n = 1; n < 120; n++) begin
      if (mem_cs_n != 4'hF) begin
        if (first_cs < 0) first_cs = n;
        last_cs = n;
        if (mem_cs_n != ~(4'b0001 << b)) bad_cs++;
        if (mem_addr != off) bad_addr++;
      end
      if (!mem_oe_n || !mem_we_n) begin
        if (first_stb < 0) first_stb = n;
        stb_cnt++;
        if (wr ? !mem_oe_n : !mem_we_n) bad_strobe++;
      end
      if (mem_dq_oe) begin
        if (oe_first < 0) oe_first = n;
        oe_last = n;
        oe_cnt_l++;
        if (mem_dq_out != wd) bad_wdata++;
      end
      if (ack) begin
        ack_n = n;
        rd_at_ack = rdata;
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    // R2
    check(bad_cs == 0 && first_cs == 1, "R2 chip select of addressed bank", bad_cs, 0);
    // R3
    check(bad_addr == 0, "R3 address steady and correct", bad_addr, 0);
    // R4
    check(first_stb == exp_a[b] + 1, "R4 strobe delay after chip select", first_stb - 1, exp_a[b]);
    // R5
    check(stb_cnt == dm, "R5 strobe width", stb_cnt, dm);
    // R6
    check(last_cs == len, "R6 chip select length incl. hold/turnaround", last_cs, len);
    check(ack_n == len + 1, "R6 ack clock after chip select release", ack_n, len + 1);
    // R7
    check(!ack, "R7 ack lasts one clock", int'(ack), 0);
    check(bad_strobe == 0, "R7/R8 correct strobe used", bad_strobe, 0);
    if (wr) begin
      // R8
      check(oe_cnt_l == exp_a[b] + dm + exp_h[b] && oe_first == 1 && bad_wdata == 0,
            "R8 data-bus drive window", oe_cnt_l, exp_a[b] + dm + exp_h[b]);
    end else begin
      // R7: sample taken on last data-setup clock
      check(rd_at_ack == model_base(off) + 16'(dm - 1), "R7 read data sample clock",
            int'(rd_at_ack), int'(model_base(off) + 16'(dm - 1)));
      check(oe_cnt_l == 0, "R8 data bus released on read", oe_cnt_l, 0);
    end
  endtask

  task automatic test_reset();
    // R1
    check(mem_cs_n == 4'hF, "R1 chip selects idle high", int'(mem_cs_n), 15);
    check(mem_oe_n && mem_we_n, "R1 strobes idle high", int'({mem_oe_n, mem_we_n}), 3);
    check(!mem_dq_oe && !ack && req_ready, "R1 bus released, ready, no ack",
          int'({mem_dq_oe, ack, req_ready}), 1);
  endtask

  task automatic test_busy_ignore();
    int cs_b1, extra;
    cs_b1 = 0; extra = 0;
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = {2'd3, 28'h0000040}; req_wdata = '0;
    @(negedge clk);
    // R10
    check(!req_ready, "R10 ready low while busy", int'(req_ready), 0);
    req_addr = {2'd1, 28'h0000050};
    for (int i = 0; i < 4; i++) begin
      if (!mem_cs_n[1]) cs_b1++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    for (int i = 0; i < 60 && !ack; i++) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (mem_cs_n != 4'hF) extra++;
    end
    // R10
    check(cs_b1 == 0, "R10 held request ignored while busy", cs_b1, 0);
    check(extra == 0, "R10 exactly one bus cycle per request", extra, 0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_bank = '0;
    cfg_addset = '0; cfg_datset = '0; cfg_hold = '0; cfg_turn = '0;
    req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    mem_dq_in = 16'hFFFF;
    for (int b = 0; b < 4; b++) begin
      exp_a[b] = 14; exp_d[b] = 16; exp_h[b] = 0; exp_t[b] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    test_reset();
    access(0, 1'b0, 28'h0000123, 16'h0);      // default timing read
    access(1, 1'b1, 28'h0ABCDEF, 16'hBEEF);   // default timing write
    set_timing(2, 0, 0, 0, 0);                // all-zero corner
    access(2, 1'b0, 28'h0000007, 16'h0);
    access(2, 1'b1, 28'h0000008, 16'h1234);
    set_timing(3, 2, 3, 2, 3);
    access(3, 1'b1, 28'h0FFFFFF, 16'hA55A);
    access(3, 1'b0, 28'h0000777, 16'h0);
    // R9: banks 0 and 1 keep their own counts after other banks change
    access(0, 1'b1, 28'h0000010, 16'h0F0F);
    access(1, 1'b0, 28'h0000020, 16'h0);
    test_busy_ignore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule